// File: doc/BRIEF.md
# Tile Wrapper with Program Loader

This block sits between one port of an on-chip packet network and a small 16-bit embedded controller that has no interrupt input. Every message that arrives from the network passes through it, and the header flit of each message decides where the message goes. A message addressed to the reserved configuration port carries new code. Its words are written into a 1024-word, 18-bit instruction store through that store's write port. A message to any other port carries application data for the running task. Its payload goes into a small input FIFO, and the controller drains that FIFO at its own pace.

While new code is being written, the controller is kept in reset, and its fetch stub stops. When the configuration message ends, the controller is released and fetches again from address 0 through the read port of the instruction store. Application data that arrives before or around a load stays in the FIFO until the controller runs again. Words produced by the controller go back to the network through a one-entry output register. A configuration message whose write address would run past the last instruction word is aborted and raises a sticky error flag.

Top module: `tile_loader_wrap`

## Requirements
- R1: A header flit (in_first high) whose bits [3:0] equal 15 opens a configuration message. Any other value opens a data message. A data message never changes the instruction store.
- R2: In a configuration message, bits [9:0] of the second flit give the start address. Each later flit is written as one 18-bit word, at the start address for the first word and one address higher for each word after it.
- R3: core_run goes low in the cycle after a configuration header with in_last low is accepted. It stays low until the cycle after the final flit of that message is accepted.
- R4: After core_run rises, fetch_valid rises one cycle later with fetch_pc equal to 0. fetch_pc then steps by one every cycle, and fetch_word always shows the stored word at fetch_pc.
- R5: Bits [15:0] of each payload flit of a data message (the header is excluded) appear on rx_data in arrival order. rx_valid is high while the FIFO holds an entry, and rx_pop removes the head.
- R6: in_ready is low during a data message while the FIFO holds 4 words. No payload word is lost, and words buffered before a load are still delivered after it.
- R7: rx_pop has no effect while core_run is low.
- R8: A word that arrives after address 1023 has been written is not stored. cfg_error goes high, and the rest of the message is discarded without reaching the FIFO. cfg_error stays high until the next configuration header is accepted.
- R9: A word on tx_data is taken when tx_valid and tx_ready are both high. It appears on out_data with out_valid one cycle later and holds until out_ready is high. tx_ready is high when the output register is empty or is being emptied.
- R10: While rst_n is low, in_ready is high, and out_valid, rx_valid, fetch_valid and cfg_error are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Incoming flit valid |
| in_ready | output | 1 | Incoming flit accepted when high |
| in_first | input | 1 | Flit is a message header |
| in_last | input | 1 | Flit ends the message |
| in_data | input | 18 | Flit contents |
| rx_valid | output | 1 | Data FIFO holds a word |
| rx_data | output | 16 | Head of the data FIFO |
| rx_pop | input | 1 | Controller removes the head word |
| tx_valid | input | 1 | Controller offers an output word |
| tx_data | input | 16 | Controller output word |
| tx_ready | output | 1 | Output word accepted when high |
| out_valid | output | 1 | Outgoing word valid |
| out_data | output | 16 | Outgoing word |
| out_ready | input | 1 | Network takes the outgoing word |
| core_run | output | 1 | Controller released from reset |
| fetch_valid | output | 1 | Fetch stub output valid |
| fetch_pc | output | 10 | Address being fetched |
| fetch_word | output | 18 | Instruction word at fetch_pc |
| cfg_error | output | 1 | Sticky load-overflow flag |

## Verification
The assertions assume that the incoming stream is well formed. Every message starts with a flit that has in_first set and ends with one that has in_last set, and no header appears inside a message. The bench builds its messages with a task that always produces this framing. It holds in_valid and the flit steady until the flit is accepted, and it issues rx_pop only when rx_valid is high. The random ports and payloads, including random upper bits in the data flits, stay inside that framing.

// File: rtl/tlw_pkg.sv
package tlw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CADDR = 3'd1,
        ST_CDATA = 3'd2,
        ST_DATA  = 3'd3,
        ST_DRAIN = 3'd4
    } steer_st_e;

endpackage

// File: rtl/tlw_steer.sv
module tlw_steer
    import tlw_pkg::*;
#(
    parameter int WORD_W   = 18,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 10,
    parameter int PORT_W   = 4,
    parameter int CFG_PORT = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic              in_last,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    input  logic              fifo_full,
    output logic              fifo_push,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              core_run,
    output logic              cfg_error
);

    localparam logic [PORT_W-1:0] CFG_ID  = CFG_PORT[PORT_W-1:0];
    localparam logic [ADDR_W:0]   ADDR_INC = (ADDR_W+1)'(1);

    typedef struct packed {
        steer_st_e       state;
        logic [ADDR_W:0] addr;
        logic            run;
        logic            err;
    } steer_t;

    steer_t s_d, s_q;
    logic   acc;
    logic   is_cfg;

    assign in_ready   = (s_q.state == ST_DATA) ? !fifo_full : 1'b1;
    assign acc        = in_valid && in_ready;
    assign is_cfg     = (in_data[PORT_W-1:0] == CFG_ID);
    assign fifo_wdata = in_data[DATA_W-1:0];
    assign mem_waddr  = s_q.addr[ADDR_W-1:0];
    assign mem_wdata  = in_data;
    assign core_run   = s_q.run;
    assign cfg_error  = s_q.err;

    always_comb begin
        s_d       = s_q;
        fifo_push = 1'b0;
        mem_we    = 1'b0;
        case (s_q.state)
            ST_IDLE: begin
                if (acc && in_first) begin
                    if (is_cfg) begin
                        s_d.err = 1'b0;
                        if (!in_last) s_d.state = ST_CADDR;
                    end else if (!in_last) begin
                        s_d.state = ST_DATA;
                    end
                end
            end
            ST_CADDR: begin
                if (acc) begin
                    s_d.addr  = {1'b0, in_data[ADDR_W-1:0]};
                    s_d.state = in_last ? ST_IDLE : ST_CDATA;
                end
            end
            ST_CDATA: begin
                if (acc) begin
                    if (s_q.addr[ADDR_W]) begin
                        s_d.err   = 1'b1;
                        s_d.state = in_last ? ST_IDLE : ST_DRAIN;
                    end else begin
                        mem_we    = 1'b1;
                        s_d.addr  = s_q.addr + ADDR_INC;
                        s_d.state = in_last ? ST_IDLE : ST_CDATA;
                    end
                end
            end
            ST_DATA: begin
                fifo_push = acc;
                if (acc && in_last) s_d.state = ST_IDLE;
            end
            ST_DRAIN: begin
                if (acc && in_last) s_d.state = ST_IDLE;
            end
            default: s_d.state = ST_IDLE;
        endcase
        s_d.run = (s_d.state == ST_IDLE) || (s_d.state == ST_DATA);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, addr: '0, run: 1'b1, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    // R3: accepting a multi-flit configuration header stops the controller
    a_r3_hold_on_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_IDLE && in_valid && in_first && !in_last &&
         in_data[PORT_W-1:0] == CFG_ID) |=> !core_run);

    // R3: the controller is only released by the final flit of a message
    a_r3_release_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_run) |-> $past(in_valid && in_last));

    // R8: once the error flag is up, nothing is written to the store
    a_r8_no_write_after_err: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |-> !mem_we);

endmodule

// File: rtl/tlw_imem.sv
module tlw_imem #(
    parameter int WORD_W = 18,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              run,
    output logic              fetch_valid,
    output logic [ADDR_W-1:0] fetch_pc,
    output logic [WORD_W-1:0] fetch_word
);

    localparam int              DEPTH  = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] PC_INC = ADDR_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] shown_pc;
        logic              vld;
    } fetch_t;

    fetch_t f_d, f_q;
    logic [WORD_W-1:0] store [DEPTH];
    logic [WORD_W-1:0] rd_q;

    always_comb begin
        f_d          = f_q;
        f_d.pc       = run ? (f_q.pc + PC_INC) : '0;
        f_d.shown_pc = f_q.pc;
        f_d.vld      = run;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    always_ff @(posedge clk) begin
        rd_q <= store[f_q.pc];
        if (we) store[waddr] <= wdata;
    end

    assign fetch_valid = f_q.vld;
    assign fetch_pc    = f_q.shown_pc;
    assign fetch_word  = rd_q;

    // R4: the fetch stub starts from address zero when released
    a_r4_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (f_q.pc == '0));

endmodule

// File: rtl/tlw_fifo.sv
module tlw_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);

    localparam int             PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] PTR_INC  = PTR_W'(1);
    localparam logic [PTR_W:0]   CNT_INC  = (PTR_W+1)'(1);
    localparam logic [PTR_W:0]   CNT_MAX  = (PTR_W+1)'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [PTR_W:0]   cnt;
    } fifo_t;

    fifo_t  p_d, p_q;
    logic [W-1:0] slots [DEPTH];
    logic   do_push, do_pop;

    assign full    = (p_q.cnt == CNT_MAX);
    assign empty   = (p_q.cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = slots[p_q.rp];

    always_comb begin
        p_d = p_q;
        if (do_push) p_d.wp = (p_q.wp == PTR_LAST) ? '0 : p_q.wp + PTR_INC;
        if (do_pop)  p_d.rp = (p_q.rp == PTR_LAST) ? '0 : p_q.rp + PTR_INC;
        case ({do_push, do_pop})
            2'b10:   p_d.cnt = p_q.cnt + CNT_INC;
            2'b01:   p_d.cnt = p_q.cnt - CNT_INC;
            default: p_d.cnt = p_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) slots[p_q.wp] <= wdata;
    end

    // R6: the steering logic never pushes into a full FIFO
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);

    // R5: the head word stays put until it is popped
    a_r5_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !pop) |=> $stable(rdata));

endmodule

// File: rtl/tile_loader_wrap.sv
module tile_loader_wrap #(
    parameter int WORD_W     = 18,
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 10,
    parameter int PORT_W     = 4,
    parameter int CFG_PORT   = 15,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_first,
    input  logic              in_last,
    input  logic [WORD_W-1:0] in_data,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    input  logic              rx_pop,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready,
    output logic              core_run,
    output logic              fetch_valid,
    output logic [ADDR_W-1:0] fetch_pc,
    output logic [WORD_W-1:0] fetch_word,
    output logic              cfg_error
);

    logic              fifo_full, fifo_empty, fifo_push, fifo_pop;
    logic [DATA_W-1:0] fifo_wdata;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [WORD_W-1:0] mem_wdata;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } egress_t;

    egress_t e_d, e_q;

    tlw_steer #(
        .WORD_W(WORD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .PORT_W(PORT_W), .CFG_PORT(CFG_PORT)
    ) steer_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_first(in_first), .in_last(in_last),
        .in_data(in_data), .in_ready(in_ready),
        .fifo_full(fifo_full), .fifo_push(fifo_push), .fifo_wdata(fifo_wdata),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .core_run(core_run), .cfg_error(cfg_error)
    );

    tlw_imem #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) imem_i (
        .clk(clk), .rst_n(rst_n),
        .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .run(core_run),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .fetch_word(fetch_word)
    );

    assign fifo_pop = rx_pop && core_run && !fifo_empty;

    tlw_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n),
        .push(fifo_push), .wdata(fifo_wdata),
        .pop(fifo_pop), .rdata(rx_data),
        .full(fifo_full), .empty(fifo_empty)
    );

    assign rx_valid = !fifo_empty;

    // output register back to the network
    assign tx_ready = !e_q.vld || out_ready;

    always_comb begin
        e_d = e_q;
        if (e_q.vld && out_ready) e_d.vld = 1'b0;
        if (tx_valid && tx_ready) begin
            e_d.vld  = 1'b1;
            e_d.data = tx_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign out_valid = e_q.vld;
    assign out_data  = e_q.data;

    // R9: a word waiting for the network is held unchanged
    a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: tb/tile_loader_wrap_tb_top.sv
module tile_loader_wrap_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_first, in_last;
    logic [17:0] in_data;
    logic        in_ready;
    logic        rx_valid, rx_pop;
    logic [15:0] rx_data;
    logic        tx_valid, tx_ready;
    logic [15:0] tx_data;
    logic        out_valid, out_ready;
    logic [15:0] out_data;
    logic        core_run, fetch_valid, cfg_error;
    logic [9:0]  fetch_pc;
    logic [17:0] fetch_word;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    logic [17:0] mem_m [1024];
    bit          known [1024];
    logic [15:0] rxq [$];
    logic [15:0] txq [$];
    int          cfg_addr;
    bit          exp_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    tile_loader_wrap dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_first(in_first),
        .in_last(in_last), .in_data(in_data),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_pop(rx_pop),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .core_run(core_run), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .fetch_word(fetch_word), .cfg_error(cfg_error)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after acceptance
    task automatic send_flit(input bit first, input bit last, input logic [17:0] d);
        in_valid = 1'b1; in_first = first; in_last = last; in_data = d;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    endtask

    function automatic logic [17:0] hdr(input int port);
        return {14'($urandom), 4'(port)};
    endfunction

    task automatic cfg_begin(input int start);
        send_flit(1'b1, 1'b0, hdr(15));
        chk("R3 hold after cfg header", 32'(core_run), 32'd0);
        send_flit(1'b0, 1'b0, {8'($urandom), 10'(start)});
        cfg_addr = start;
        exp_err  = 1'b0;
    endtask

    task automatic cfg_word(input logic [17:0] w, input bit last);
        send_flit(1'b0, last, w);
        if (cfg_addr < 1024) begin
            mem_m[cfg_addr] = w;
            known[cfg_addr] = 1'b1;
            cfg_addr++;
        end else begin
            exp_err = 1'b1;
        end
        if (!last) chk("R3 hold during load", 32'(core_run), 32'd0);
    endtask

    task automatic cfg_load(input int start, input int n);
        cfg_begin(start);
        for (int i = 0; i < n; i++) cfg_word(18'($urandom), i == n - 1);
    endtask

    task automatic check_fetch(input string tag);
        int guard = 0;
        while (!fetch_valid && guard < 10) begin
            @(negedge clk);
            guard++;
        end
        chk({tag, " R4 restart at 0"}, 32'(fetch_pc), 32'd0);
        for (int k = 0; k < 16; k++) begin
            chk({tag, " R4 pc step"}, 32'(fetch_pc), 32'(k));
            if (known[k]) chk({tag, " R2/R4 stored word"}, 32'(fetch_word), 32'(mem_m[k]));
            @(negedge clk);
        end
    endtask

    task automatic data_msg(input int port, input int len);
        send_flit(1'b1, len == 0, hdr(port));
        for (int i = 0; i < len; i++) begin
            logic [17:0] d;
            d = 18'($urandom);
            rxq.push_back(d[15:0]);
            send_flit(1'b0, i == len - 1, d);
        end
    endtask

    task automatic pop_one(input string tag);
        chk({tag, " R5 rx_valid"}, 32'(rx_valid), 32'd1);
        chk({tag, " R5 rx_data order"}, 32'(rx_data), 32'(rxq[0]));
        rx_pop = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rx_pop = 1'b0;
        void'(rxq.pop_front());
    endtask

    task automatic drain_rx(input string tag);
        while (rxq.size() > 0) pop_one(tag);
        chk({tag, " R5 fifo empty"}, 32'(rx_valid), 32'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd4711));
        for (int i = 0; i < 1024; i++) known[i] = 1'b0;
        rst_n = 1'b0; in_valid = 0; in_first = 0; in_last = 0; in_data = '0;
        rx_pop = 0; tx_valid = 0; tx_data = '0; out_ready = 0;
        repeat (4) @(negedge clk);
        chk("R10 in_ready", 32'(in_ready), 32'd1);
        chk("R10 out_valid", 32'(out_valid), 32'd0);
        chk("R10 rx_valid", 32'(rx_valid), 32'd0);
        chk("R10 fetch_valid", 32'(fetch_valid), 32'd0);
        chk("R10 cfg_error", 32'(cfg_error), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed load at address 0
        cfg_load(0, 16);
        chk("R3 released after load", 32'(core_run), 32'd1);
        check_fetch("directed");

        // R1: a data message to port 14 never touches the store
        data_msg(14, 3);
        chk("R1 data reached fifo", 32'(rx_valid), 32'd1);
        cfg_load(600, 1);
        check_fetch("R1 store untouched");
        drain_rx("R1");

        // random mix of loads and data messages
        for (int it = 0; it < 12; it++) begin
            if ($urandom_range(0, 1) == 1) begin
                int st;
                st = $urandom_range(0, 14);
                cfg_load(st, $urandom_range(1, 8));
                chk("R8 no error in range", 32'(cfg_error), 32'd0);
                check_fetch("random load");
            end else begin
                int len;
                len = $urandom_range(1, 4);
                if (rxq.size() + len > 4) drain_rx("random");
                data_msg($urandom_range(0, 14), len);
            end
        end
        drain_rx("random end");

        // R6: backpressure on a full FIFO
        data_msg(3, 4);
        send_flit(1'b1, 1'b0, hdr(5));
        in_valid = 1'b1; in_first = 1'b0; in_last = 1'b1; in_data = 18'h2abcd;
        @(negedge clk);
        chk("R6 in_ready low when full", 32'(in_ready), 32'd0);
        repeat (3) @(negedge clk);
        chk("R6 in_ready stays low", 32'(in_ready), 32'd0);
        pop_one("R6 pop while stalled");
        rxq.push_back(16'habcd);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        chk("R6 no flit lost", 32'(rxq.size()), 32'd4);
        drain_rx("R6");

        // R6/R7: data buffered across a load, pops ignored while held
        data_msg(9, 2);
        cfg_begin(20);
        rx_pop = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rx_pop = 1'b0;
        chk("R7 pop ignored while held", 32'(rx_data), 32'(rxq[0]));
        chk("R7 rx_valid kept", 32'(rx_valid), 32'd1);
        cfg_word(18'h15a5a, 1'b0);
        cfg_word(18'h0a5a5, 1'b1);
        check_fetch("after held load");
        drain_rx("R6 buffered across load");

        // R8: overflow past the last word
        cfg_begin(1022);
        for (int i = 0; i < 4; i++) cfg_word(18'($urandom), i == 3);
        chk("R8 model expects error", 32'(exp_err), 32'd1);
        chk("R8 cfg_error set", 32'(cfg_error), 32'd1);
        chk("R8 drained flits not in fifo", 32'(rx_valid), 32'd0);
        check_fetch("R8 no wrap write");
        data_msg(2, 1);
        chk("R8 error kept over data msg", 32'(cfg_error), 32'd1);
        drain_rx("R8");
        cfg_load(100, 1);
        chk("R8 error cleared by new load", 32'(cfg_error), 32'd0);

        // R9: directed hold
        @(negedge clk);
        tx_valid = 1'b1; tx_data = 16'h1234; out_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        chk("R9 out_valid", 32'(out_valid), 32'd1);
        chk("R9 out_data", 32'(out_data), 32'h1234);
        chk("R9 tx_ready low while full", 32'(tx_ready), 32'd0);
        @(negedge clk);
        chk("R9 held", 32'(out_data), 32'h1234);
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R9 consumed", 32'(out_valid), 32'd0);

        // R9: random egress stream
        begin
            bit pend;
            pend = 1'b0;
            for (int i = 0; i < 90; i++) begin
                out_ready = (i >= 70) ? 1'b1 : 1'($urandom_range(0, 1));
                if (!pend) begin
                    tx_valid = (i < 60) && ($urandom_range(0, 3) != 0);
                    tx_data  = 16'($urandom);
                end
                #1;
                if (out_valid && out_ready) begin
                    if (txq.size() == 0) chk("R9 unexpected word", 32'(out_data), 32'hffffffff);
                    else begin
                        chk("R9 stream order", 32'(out_data), 32'(txq[0]));
                        void'(txq.pop_front());
                    end
                end
                if (tx_valid && tx_ready) begin
                    txq.push_back(tx_data);
                    pend = 1'b0;
                end else begin
                    pend = tx_valid;
                end
                @(negedge clk);
            end
            tx_valid = 1'b0;
            chk("R9 all words delivered", 32'(txq.size()), 32'd0);
        end

        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule